// File: doc/BRIEF.md
# Masked Interrupt Level Encoder

This block collects up to 32 interrupt sources into a sticky pending register, filters them through a disable mask, and presents a 4-bit processor priority level. The level is the largest entry of a fixed, irregular source-to-level table taken over every source that is pending and not disabled. It is 0 when no source qualifies. Several sources share a level, and some map to level 0.

Software reaches the block through a small word-addressed register port. Two write locations modify the mask. One clears mask bits, which enables those sources. The other sets mask bits and also drops the matching pending bits. Both write locations are filtered by a fixed constant, so a set of hard-wired source positions can never be masked. Their pending bits also can never be cleared by software. Two read locations return the pending register and the mask.

Top module: `irq_level_enc`

## Requirements
- R1: After reset, pending reads 0x00000000, the mask reads 0xB04DFF80 (every maskable bit disabled), and level_o is 0.
- R2: A write to offset 2 clears, in the mask, every written bit that is maskable; those sources are enabled from the next cycle on.
- R3: The bit positions set in 0x4FB2007F are forced to zero in the write data of offsets 2 and 3, so their mask bits stay 0 and their pending bits are never cleared by a write.
- R4: A write to offset 3 sets, in the mask, every written bit that is maskable, and clears the same bits in the pending register.
- R5: A source input sampled high sets its pending bit, which stays set until an offset-3 write clears it; if the source is high in the same cycle as that write, the pending bit stays set.
- R6: Source bits 0 to 15 carry levels 2, 3, 5, 7, 9, 11, 0, 14, 3, 5, 7, 9, 11, 13, 12, 12 in ascending bit order.
- R7: Source bits 16 to 31 carry levels 6, 0, 4, 10, 8, 0, 11, 0, 0, 0, 0, 0, 15, 0, 15, 0 in ascending bit order.
- R8: level_o is the largest table level over all bits that are pending and not masked, and 0 if none; a masked pending source keeps its pending bit but adds nothing.
- R9: level_o is registered and shows the effect of a source or write sampled at a clock edge right after that same edge, and not before it.
- R10: Offset 0 reads pending, offset 1 reads the mask, offsets 2 and 3 read 0; writes to offsets 0 and 1 change nothing. rdata_o follows addr_i without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source inputs, sampled each edge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| level_o | output | 4 | Highest active priority level |

## Verification
Every source pulse and mask write is applied for exactly one edge. The level it produces is due right after that edge, so the driver queues the expected level as soon as the edge has passed and the monitor compares it at the following falling edge. One check looks at level_o after new inputs are driven but before the edge, to confirm that nothing leaks through early. Register readbacks are combinational and are checked one time unit after addr_i is set, with the write strobe low.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned SRC_N  = 32;
  localparam int unsigned LEVEL_W = 4;
  localparam logic [SRC_N-1:0] FIXED_BITS = 32'h4FB2_007F;

  localparam logic [1:0] OFF_PEND = 2'd0;
  localparam logic [1:0] OFF_MASK = 2'd1;
  localparam logic [1:0] OFF_EN   = 2'd2;
  localparam logic [1:0] OFF_DIS  = 2'd3;

  // Irregular source-to-level map; indices past the table give 0
  function automatic logic [LEVEL_W-1:0] src_level(input int idx);
    case (idx)
      0: return 4'd2;    1: return 4'd3;    2: return 4'd5;    3: return 4'd7;
      4: return 4'd9;    5: return 4'd11;   6: return 4'd0;    7: return 4'd14;
      8: return 4'd3;    9: return 4'd5;    10: return 4'd7;   11: return 4'd9;
      12: return 4'd11;  13: return 4'd13;  14: return 4'd12;  15: return 4'd12;
      16: return 4'd6;   17: return 4'd0;   18: return 4'd4;   19: return 4'd10;
      20: return 4'd8;   21: return 4'd0;   22: return 4'd11;  28: return 4'd15;
      30: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_lvl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] FIXED = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               en_wr_i,
  input  logic               dis_wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] pend_q_o,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic [NUM_SRC-1:0] pend_d_o,
  output logic [NUM_SRC-1:0] mask_d_o
);
  localparam logic [NUM_SRC-1:0] MASKABLE = ~FIXED;

  logic [NUM_SRC-1:0] wv, pend_q, mask_q, pend_d, mask_d;

  assign wv = wdata_i & MASKABLE;

  always_comb begin
    pend_d = (pend_q & ~(dis_wr_i ? wv : '0)) | src_i;
    mask_d = mask_q;
    if (en_wr_i)       mask_d = mask_q & ~wv;
    else if (dis_wr_i) mask_d = mask_q | wv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= MASKABLE;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign pend_q_o = pend_q;
  assign mask_q_o = mask_q;
  assign pend_d_o = pend_d;
  assign mask_d_o = mask_d;

  p_unmask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> ((mask_q & $past(wdata_i & MASKABLE)) == '0));
  p_fixed_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & FIXED) == '0);
  p_mask_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr_i |=> ((mask_q & $past(wdata_i & MASKABLE)) == $past(wdata_i & MASKABLE)));
  p_pend_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr_i |=> ((pend_q & $past(wdata_i & MASKABLE & ~src_i)) == '0));
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((pend_q & $past(src_i)) == $past(src_i)));
endmodule

// File: rtl/irq_lvl_lookup.sv
module irq_lvl_lookup
  import irq_lvl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 4
) (
  input  logic [NUM_SRC-1:0]       act_i,
  output logic [NUM_SRC*LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [LVL_W-1:0] LV = LVL_W'(src_level(g));
    assign lvl_o[g*LVL_W +: LVL_W] = act_i[g] ? LV : '0;
  end
endmodule

// File: rtl/irq_lvl_max.sv
module irq_lvl_max #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 4
) (
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]         max_o
);
  always_comb begin
    max_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (lvl_i[i*LVL_W +: LVL_W] > max_o) max_o = lvl_i[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_lvl_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_N,
  parameter int unsigned LVL_W   = LEVEL_W,
  parameter int unsigned OFF_W   = 2,
  parameter logic [NUM_SRC-1:0] FIXED = FIXED_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [OFF_W-1:0]   addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [LVL_W-1:0]   level_o
);
  logic en_wr, dis_wr;
  logic [NUM_SRC-1:0] pend_q, mask_q, pend_d, mask_d;
  logic [NUM_SRC*LVL_W-1:0] lvl_vec;
  logic [LVL_W-1:0] lvl_max, level_q;

  assign en_wr  = wr_en_i && (addr_i == OFF_W'(OFF_EN));
  assign dis_wr = wr_en_i && (addr_i == OFF_W'(OFF_DIS));

  irq_mask_regs #(.NUM_SRC(NUM_SRC), .FIXED(FIXED)) u_regs (
    .clk_i, .rst_ni, .src_i,
    .en_wr_i(en_wr), .dis_wr_i(dis_wr), .wdata_i,
    .pend_q_o(pend_q), .mask_q_o(mask_q),
    .pend_d_o(pend_d), .mask_d_o(mask_d)
  );

  // Level is looked up from next state so it lands on the same edge
  irq_lvl_lookup #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lookup (
    .act_i(pend_d & ~mask_d), .lvl_o(lvl_vec)
  );

  irq_lvl_max #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_max (
    .lvl_i(lvl_vec), .max_o(lvl_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= lvl_max;
  end

  always_comb begin
    case (addr_i)
      OFF_W'(OFF_PEND): rdata_o = pend_q;
      OFF_W'(OFF_MASK): rdata_o = mask_q;
      default:          rdata_o = '0;
    endcase
  end

  assign level_o = level_q;

  p_quiet_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~mask_q) == '0) |-> (level_q == '0));
  p_wr_low_mask_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_wr || dis_wr) |=> $stable(mask_q));
endmodule

// File: tb/tb_irq_level_enc.sv
module tb_irq_level_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  level;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_lvl_q[$];
  string exp_tag_q[$];

  int ref_lvl[32] = '{2, 3, 5, 7, 9, 11, 0, 14, 3, 5, 7, 9, 11, 13, 12, 12,
                      6, 0, 4, 10, 8, 0, 11, 0, 0, 0, 0, 0, 15, 0, 15, 0};

  always #4 clk = ~clk;

  irq_level_enc dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .level_o(level)
  );

  task automatic check(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares queued level expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_lvl_q.size() > 0) begin
        int e;
        string t;
        e = exp_lvl_q.pop_front();
        t = exp_tag_q.pop_front();
        check(longint'(level), longint'(e), t);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [31:0] s, input logic w, input logic [1:0] a,
                      input logic [31:0] d, input int exp, input string tag);
    @(negedge clk);
    src = s; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    src = '0; we = 1'b0;
    exp_lvl_q.push_back(exp);
    exp_tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    check(longint'(rdata), longint'(exp), tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    check(longint'(level), 0, "R1 level after reset");
    rd(2'd0, 32'h0000_0000, "R1 pending after reset");
    rd(2'd1, 32'hB04D_FF80, "R1 mask after reset");

    // R8 masked pending source keeps pending, adds nothing
    step(32'h0000_0080, 1'b0, 2'd0, '0, 0, "R8 masked source level 0");
    rd(2'd0, 32'h0000_0080, "R8 masked source still pending");
    // R2 enable through offset 2
    step('0, 1'b1, 2'd2, 32'h0000_0080, 14, "R2 unmask bit 7 raises level");
    rd(2'd1, 32'hB04D_FF00, "R2 mask bit 7 cleared");

    // R8 maximum selection and R4 set-and-clear
    do_reset();
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 0, "R2 unmask all, nothing pending");
    rd(2'd1, 32'h0000_0000, "R2 mask fully cleared");
    step(32'h0010_2080, 1'b0, 2'd0, '0, 14, "R8 max of 14,13,8");
    step('0, 1'b1, 2'd3, 32'h0000_0080, 13, "R4 disable bit 7 drops to 13");
    rd(2'd0, 32'h0010_2000, "R4 pending bit 7 cleared");
    rd(2'd1, 32'h0000_0080, "R4 mask bit 7 set");
    step('0, 1'b1, 2'd2, 32'h0000_0080, 13, "R4 re-enable after clear stays 13");
    step('0, 1'b1, 2'd3, 32'h0000_2000, 8, "R8 next highest is 8");
    step('0, 1'b0, 2'd0, '0, 8, "R5 pending sticky while idle");

    // R3 fixed positions ignore both mask writes
    do_reset();
    step(32'h0000_0003, 1'b0, 2'd0, '0, 3, "R3 fixed sources active at reset");
    step('0, 1'b1, 2'd3, 32'hFFFF_FFFF, 3, "R3 disable-all leaves fixed bits");
    rd(2'd1, 32'hB04D_FF80, "R3 mask only maskable bits set");
    rd(2'd0, 32'h0000_0003, "R3 fixed pending not cleared");
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 3, "R3 enable-all level unchanged");
    rd(2'd1, 32'h0000_0000, "R3 mask cleared by enable-all");

    // R5 source high in same cycle as clear wins
    do_reset();
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 0, "R5 unmask all");
    step(32'h0000_0200, 1'b1, 2'd3, 32'h0000_0200, 0, "R5 masked while set");
    rd(2'd0, 32'h0000_0200, "R5 pending survives same-cycle clear");
    rd(2'd1, 32'h0000_0200, "R5 mask bit 9 set");
    step('0, 1'b1, 2'd2, 32'h0000_0200, 5, "R5 re-enable shows level 5");

    // R10 read-only offsets and zero reads
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, 5, "R10 write offset 0 no effect");
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, 5, "R10 write offset 1 no effect");
    rd(2'd0, 32'h0000_0200, "R10 pending unchanged");
    rd(2'd1, 32'h0000_0000, "R10 mask unchanged");
    rd(2'd2, 32'h0000_0000, "R10 offset 2 reads zero");
    rd(2'd3, 32'h0000_0000, "R10 offset 3 reads zero");

    // R9 nothing before the edge, result right after it
    do_reset();
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 0, "R9 unmask all");
    @(negedge clk);
    src = 32'h1000_0000;
    #1;
    check(longint'(level), 0, "R9 level unchanged before edge");
    @(posedge clk);
    #1;
    src = '0;
    exp_lvl_q.push_back(15);
    exp_tag_q.push_back("R9 level right after edge");

    // R6 R7 table sweep, one source per reset
    for (int i = 0; i < 32; i++) begin
      do_reset();
      step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 0, (i < 16) ? "R6 unmask" : "R7 unmask");
      step(32'h1 << i, 1'b0, 2'd0, '0, ref_lvl[i],
           $sformatf("%s level of bit %0d", (i < 16) ? "R6" : "R7", i));
      rd(2'd0, 32'h1 << i, $sformatf("%s pending of bit %0d", (i < 16) ? "R6" : "R7", i));
    end

    wait (exp_lvl_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule